// File: doc/BRIEF.md
# Three-Phase Commutation Sequencer with Brake Control

This block steps a three-phase half-bridge driver through its six commutation steps. Each rising edge of an external commutation clock moves it to the next step, and step 6 wraps to step 1. Each step is decoded into six gate enables, one upper and one lower enable per phase. For each phase the result is upper-on, lower-on or both off (floating). The block also routes one per-phase back-EMF comparator bit to a single output. Either the phase that floats in the present step is reported, or phase C is reported at all times.

All control inputs are asynchronous to the system clock. They pass through a shared synchroniser of `SYNC_STAGES` flops before any decision is made. The commutation clock is then edge-detected in the system domain.

The step register holds one of `ST1` to `ST6`. It has three transitions:

- advance: a synchronised rising edge with the initialise input low, giving `ST(n) -> ST(n+1)` and `ST6 -> ST1`;
- initialise: the initialise input high with the commutation clock low, forcing `ST1`;
- brake-initialise: an immediate brake, also forcing `ST1`.

A separate mode decode picks one of five drive modes. In priority order from highest to lowest they are:

1. `MD_HOT`: over-temperature, every driver off.
2. `MD_IMM`: immediate brake, all lower switches on.
3. `MD_DLY`: delayed brake, all lower switches on.
4. `MD_TRI`: tri-state, every driver off.
5. `MD_RUN`: the step table drives the gates.

Top module: `commut_seq`

## Requirements
- R1: Each synchronised rising edge of `comm_clk` while `seq_init` is low advances the step by one: 1->2->3->4->5->6->1.
- R2: In run mode the gate enables follow this table. Bit 0 is phase A, bit 1 is phase B and bit 2 is phase C. The values are written as `hi_en`/`lo_en`: step 1 = 001/010, step 2 = 001/100, step 3 = 010/100, step 4 = 010/001, step 5 = 100/001, step 6 = 100/010.
- R3: While `seq_init` is high and `comm_clk` is low, the step is forced to 1 and the gates show step 1. Rising edges of `comm_clk` while `seq_init` is high do not advance the step.
- R4: With `seq_init` and `comm_clk` both high and `mux_mode` low, an immediate brake applies: `hi_en`=000 and `lo_en`=111, whatever `dly_brk_n` does. Afterwards the step is 1.
- R5: With `seq_init` and `comm_clk` both high and `mux_mode` high, all six gate enables are 0.
- R6: While `brk_req_n` is low and no brake is armed, all six gate enables are 0.
- R7: A falling edge of `dly_brk_n` while `brk_req_n` is low gives `hi_en`=000 and `lo_en`=111. This lasts until `brk_req_n` returns high. A falling edge while `brk_req_n` is high has no effect.
- R8: While `ot_flag` is high, all six gate enables are 0, overriding every other mode including an immediate brake.
- R9: The upper and lower enables of one phase are never both 1.
- R10: With `mux_mode` high, `bemf_out` reports the comparator bit of the floating phase. That phase is C in steps 1 and 4, B in steps 2 and 5, and A in steps 3 and 6.
- R11: With `mux_mode` low, `bemf_out` always reports `bemf_cmp[2]` (phase C).
- R12: `bemf_out` passes the selected comparator bit unchanged: 1 means above the centre tap, 0 means below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| comm_clk | input | 1 | Commutation clock; its rising edge advances the step |
| seq_init | input | 1 | Initialise / brake qualifier, combined with `comm_clk` |
| mux_mode | input | 1 | 1: back-EMF follows the floating phase; 0: phase C only |
| brk_req_n | input | 1 | Active-low brake request (tri-states all phases) |
| dly_brk_n | input | 1 | Delayed-brake input; falling edge arms the lower-side brake |
| ot_flag | input | 1 | Over-temperature flag, already with hysteresis |
| bemf_cmp | input | 3 | Per-phase comparator results, bit 0 = phase A |
| hi_en | output | 3 | Upper switch enables, bit 0 = phase A |
| lo_en | output | 3 | Lower switch enables, bit 0 = phase A |
| bemf_out | output | 1 | Selected back-EMF comparator bit |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 rather than the default 2. This shows that every decision waits for the full synchroniser depth and that nothing depends on a fixed two-flop latency. Each stimulus is held for eight system cycles, which covers the synchroniser, the edge detector and the step register. Under that setting the bench reaches every step-to-step advance and the 6->1 wrap. It also reaches the back-EMF selection in every step, and each brake mode entered from a non-initial step. Finally it covers the over-temperature override of an immediate brake and the case where a delayed-brake edge arrives with no brake request.

// File: rtl/commut_seq_pkg.sv
package commut_seq_pkg;

    localparam int NPH = 3;

    typedef enum logic [2:0] {ST1, ST2, ST3, ST4, ST5, ST6} step_t;

    typedef enum logic [2:0] {MD_RUN, MD_TRI, MD_DLY, MD_IMM, MD_HOT} mode_t;

    typedef enum logic [1:0] {PH_OFF, PH_HI, PH_LO} drv_t;

    function automatic step_t step_next(step_t s);
        step_t n;
        unique case (s)
            ST1:     n = ST2;
            ST2:     n = ST3;
            ST3:     n = ST4;
            ST4:     n = ST5;
            ST5:     n = ST6;
            default: n = ST1;
        endcase
        return n;
    endfunction

    // Packed as {phase C, phase B, phase A}, two bits each
    function automatic drv_t phase_drive(step_t s, int ph);
        logic [5:0] v;
        unique case (s)
            ST1:     v = {PH_OFF, PH_LO,  PH_HI};
            ST2:     v = {PH_LO,  PH_OFF, PH_HI};
            ST3:     v = {PH_LO,  PH_HI,  PH_OFF};
            ST4:     v = {PH_OFF, PH_HI,  PH_LO};
            ST5:     v = {PH_HI,  PH_OFF, PH_LO};
            ST6:     v = {PH_HI,  PH_LO,  PH_OFF};
            default: v = {PH_OFF, PH_OFF, PH_OFF};
        endcase
        return drv_t'(v[2*ph +: 2]);
    endfunction

    function automatic logic [1:0] float_phase(step_t s);
        logic [1:0] f;
        unique case (s)
            ST1, ST4: f = 2'd2;
            ST2, ST5: f = 2'd1;
            default:  f = 2'd0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/commut_sync.sv
module commut_sync #(
    parameter int               WIDTH   = 6,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= din;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign dout = pipe[STAGES-1];

endmodule

// File: rtl/commut_fsm.sv
module commut_fsm
    import commut_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clk_s,
    input  logic  seq_s,
    input  logic  mux_s,
    input  logic  brk_s,
    input  logic  dly_s,
    input  logic  hot_s,
    output step_t step,
    output mode_t mode
);

    logic clk_prev;
    logic dly_prev;
    logic dly_arm;
    logic init_lvl;
    logic imm_lvl;

    assign init_lvl = seq_s && !clk_s;
    assign imm_lvl  = seq_s && clk_s && !mux_s;

    // State register: step, edge history and delayed-brake arm
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step     <= ST1;
            clk_prev <= 1'b0;
            dly_prev <= 1'b1;
            dly_arm  <= 1'b0;
        end else begin
            clk_prev <= clk_s;
            dly_prev <= dly_s;
            if (brk_s)
                dly_arm <= 1'b0;
            else if (dly_prev && !dly_s)
                dly_arm <= 1'b1;
            if (init_lvl || imm_lvl)
                step <= ST1;
            else if (clk_s && !clk_prev && !seq_s)
                step <= step_next(step);
        end
    end

    // Mode decode in priority order
    always_comb begin
        if (hot_s)
            mode = MD_HOT;
        else if (imm_lvl)
            mode = MD_IMM;
        else if (dly_arm)
            mode = MD_DLY;
        else if (!brk_s || (seq_s && clk_s))
            mode = MD_TRI;
        else
            mode = MD_RUN;
    end

endmodule

// File: rtl/commut_gates.sv
module commut_gates
    import commut_seq_pkg::*;
(
    input  step_t          step,
    input  mode_t          mode,
    output logic [NPH-1:0] hi_en,
    output logic [NPH-1:0] lo_en
);

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        logic h;
        logic l;
        drv_t d;
        always_comb begin
            d = phase_drive(step, p);
            h = 1'b0;
            l = 1'b0;
            unique case (mode)
                MD_RUN: begin
                    h = (d == PH_HI);
                    l = (d == PH_LO);
                end
                MD_DLY, MD_IMM: l = 1'b1;
                default: ;
            endcase
        end
        assign hi_en[p] = h;
        assign lo_en[p] = l;
    end

endmodule

// File: rtl/commut_bemf.sv
module commut_bemf
    import commut_seq_pkg::*;
(
    input  step_t          step,
    input  logic           mux_s,
    input  logic [NPH-1:0] cmp,
    output logic           bemf_out
);

    logic [1:0] idx;

    always_comb begin
        idx      = mux_s ? float_phase(step) : 2'd2;
        bemf_out = cmp[idx];
    end

endmodule

// File: rtl/commut_seq.sv
module commut_seq
    import commut_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           comm_clk,
    input  logic           seq_init,
    input  logic           mux_mode,
    input  logic           brk_req_n,
    input  logic           dly_brk_n,
    input  logic           ot_flag,
    input  logic [NPH-1:0] bemf_cmp,
    output logic [NPH-1:0] hi_en,
    output logic [NPH-1:0] lo_en,
    output logic           bemf_out
);

    localparam int            NCTL    = 6;
    localparam logic [NCTL-1:0] CTL_RST = 6'b011000;

    logic [NCTL-1:0] ctl_s;
    logic  clk_s, seq_s, mux_s, brk_s, dly_s, hot_s;
    step_t step_w;
    mode_t mode_w;

    commut_sync #(.WIDTH(NCTL), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ot_flag, brk_req_n, dly_brk_n, mux_mode, seq_init, comm_clk}),
        .dout (ctl_s)
    );

    assign {hot_s, brk_s, dly_s, mux_s, seq_s, clk_s} = ctl_s;

    commut_fsm u_fsm (
        .clk  (clk),
        .rst_n(rst_n),
        .clk_s(clk_s),
        .seq_s(seq_s),
        .mux_s(mux_s),
        .brk_s(brk_s),
        .dly_s(dly_s),
        .hot_s(hot_s),
        .step (step_w),
        .mode (mode_w)
    );

    commut_gates u_gates (
        .step (step_w),
        .mode (mode_w),
        .hi_en(hi_en),
        .lo_en(lo_en)
    );

    commut_bemf u_bemf (
        .step    (step_w),
        .mux_s   (mux_s),
        .cmp     (bemf_cmp),
        .bemf_out(bemf_out)
    );

endmodule

// File: rtl/commut_seq_chk.sv
module commut_seq_chk
    import commut_seq_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           clk_s,
    input logic           seq_s,
    input logic           mux_s,
    input logic           hot_s,
    input step_t          step,
    input mode_t          mode,
    input logic [NPH-1:0] hi_en,
    input logic [NPH-1:0] lo_en,
    input logic [NPH-1:0] bemf_cmp,
    input logic           bemf_out
);

    logic clk_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_seen <= 1'b0;
        else        clk_seen <= clk_s;
    end

    // R1
    step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_s && !clk_seen && !seq_s) |=> (step == step_next($past(step))));

    // R4
    imm_brake_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_s && clk_s && !mux_s) |=> (step == ST1));

    // R8
    hot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hot_s |-> (hi_en == '0 && lo_en == '0));

    // R9
    no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_en & lo_en) == '0);

    // R2
    run_one_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_RUN) |-> ($countones(hi_en) == 1 && $countones(lo_en) == 1));

    // R11
    single_phase_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mux_s |-> (bemf_out == bemf_cmp[2]));

endmodule

bind commut_seq commut_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_s   (clk_s),
    .seq_s   (seq_s),
    .mux_s   (mux_s),
    .hot_s   (hot_s),
    .step    (step_w),
    .mode    (mode_w),
    .hi_en   (hi_en),
    .lo_en   (lo_en),
    .bemf_cmp(bemf_cmp),
    .bemf_out(bemf_out)
);

// File: tb/commut_seq_bench.sv
module commut_seq_bench;

    localparam int HOLD = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       comm_clk = 1'b0;
    logic       seq_init = 1'b0;
    logic       mux_mode = 1'b1;
    logic       brk_req_n = 1'b1;
    logic       dly_brk_n = 1'b1;
    logic       ot_flag = 1'b0;
    logic [2:0] bemf_cmp = 3'b000;
    logic [2:0] hi_en;
    logic [2:0] lo_en;
    logic       bemf_out;

    int n_chk = 0;
    int n_bad = 0;
    int exp_step = 1;
    bit done = 1'b0;

    always #2 clk = ~clk;

    commut_seq #(.SYNC_STAGES(3)) u_commut_seq (
        .clk(clk), .rst_n(rst_n), .comm_clk(comm_clk), .seq_init(seq_init),
        .mux_mode(mux_mode), .brk_req_n(brk_req_n), .dly_brk_n(dly_brk_n),
        .ot_flag(ot_flag), .bemf_cmp(bemf_cmp), .hi_en(hi_en), .lo_en(lo_en),
        .bemf_out(bemf_out)
    );

    function automatic logic [2:0] exp_hi(int s);
        case (s)
            1, 2:    return 3'b001;
            3, 4:    return 3'b010;
            default: return 3'b100;
        endcase
    endfunction

    function automatic logic [2:0] exp_lo(int s);
        case (s)
            1, 6:    return 3'b010;
            2, 3:    return 3'b100;
            default: return 3'b001;
        endcase
    endfunction

    function automatic int exp_float(int s);
        case (s)
            1, 4:    return 2;
            2, 5:    return 1;
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic check_gates(string tag, logic [2:0] h, logic [2:0] l);
        check(tag, {2'b00, hi_en, lo_en}, {2'b00, h, l});
    endtask

    task automatic pulse();
        comm_clk = 1'b1; settle();
        comm_clk = 1'b0; settle();
        exp_step = (exp_step == 6) ? 1 : exp_step + 1;
    endtask

    task automatic t_reset();
        check_gates("R2 reset step1", exp_hi(1), exp_lo(1));
    endtask

    task automatic t_cycle();
        for (int k = 0; k < 7; k++) begin
            pulse();
            check_gates("R1 R2 advance", exp_hi(exp_step), exp_lo(exp_step));
        end
    endtask

    task automatic t_bemf_mux();
        mux_mode = 1'b1;
        for (int k = 0; k < 6; k++) begin
            pulse();
            bemf_cmp = 3'b001 << exp_float(exp_step);
            @(negedge clk);
            check("R10 R12 float high", {7'd0, bemf_out}, 8'd1);
            bemf_cmp = ~(3'b001 << exp_float(exp_step));
            @(negedge clk);
            check("R10 R12 float low", {7'd0, bemf_out}, 8'd0);
        end
    endtask

    task automatic t_bemf_single();
        mux_mode = 1'b0; settle();
        for (int k = 0; k < 3; k++) begin
            pulse();
            bemf_cmp = 3'b100; @(negedge clk);
            check("R11 phase C high", {7'd0, bemf_out}, 8'd1);
            bemf_cmp = 3'b011; @(negedge clk);
            check("R11 phase C low", {7'd0, bemf_out}, 8'd0);
        end
        mux_mode = 1'b1; settle();
    endtask

    task automatic t_init();
        pulse(); pulse();
        seq_init = 1'b1; settle();
        exp_step = 1;
        check_gates("R3 init forces step1", exp_hi(1), exp_lo(1));
        comm_clk = 1'b1; settle();
        check_gates("R5 reset+clk mux tri", 3'b000, 3'b000);
        comm_clk = 1'b0; settle();
        seq_init = 1'b0; settle();
        check_gates("R3 edge ignored under init", exp_hi(1), exp_lo(1));
    endtask

    task automatic t_imm();
        pulse(); pulse();
        mux_mode = 1'b0; settle();
        seq_init = 1'b1; comm_clk = 1'b1; dly_brk_n = 1'b0; settle();
        check_gates("R4 immediate brake", 3'b000, 3'b111);
        dly_brk_n = 1'b1; settle();
        check_gates("R4 brake ignores delayed input", 3'b000, 3'b111);
        comm_clk = 1'b0; settle();
        seq_init = 1'b0; mux_mode = 1'b1; settle();
        exp_step = 1;
        check_gates("R4 step1 after brake", exp_hi(1), exp_lo(1));
    endtask

    task automatic t_delayed();
        pulse();
        brk_req_n = 1'b0; settle();
        check_gates("R6 request tri-state", 3'b000, 3'b000);
        dly_brk_n = 1'b0; settle();
        check_gates("R7 delayed brake lows on", 3'b000, 3'b111);
        brk_req_n = 1'b1; settle();
        check_gates("R7 cleared by request release", exp_hi(exp_step), exp_lo(exp_step));
        dly_brk_n = 1'b1; settle();
        dly_brk_n = 1'b0; settle();
        check_gates("R7 edge without request ignored", exp_hi(exp_step), exp_lo(exp_step));
        brk_req_n = 1'b0; settle();
        check_gates("R7 stale edge not armed", 3'b000, 3'b000);
        brk_req_n = 1'b1; dly_brk_n = 1'b1; settle();
    endtask

    task automatic t_hot();
        ot_flag = 1'b1; settle();
        check_gates("R8 hot all off", 3'b000, 3'b000);
        mux_mode = 1'b0; seq_init = 1'b1; comm_clk = 1'b1; settle();
        check_gates("R8 hot overrides brake", 3'b000, 3'b000);
        comm_clk = 1'b0; settle();
        seq_init = 1'b0; mux_mode = 1'b1; ot_flag = 1'b0; settle();
        exp_step = 1;
        check_gates("R8 recovery run", exp_hi(1), exp_lo(1));
        check("R9 no overlap", {5'd0, hi_en & lo_en}, 8'd0);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        t_cycle();
        t_bemf_mux();
        t_bemf_single();
        t_init();
        t_imm();
        t_delayed();
        t_hot();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

endmodule